// File: doc/BRIEF.md
# Masked Packed Float Square Root Unit

This block takes the square root of every single-precision element in a packed vector of 4, 8 or 16 lanes. A single iterative engine does the work. It produces one root bit per cycle and visits the lanes one after another. A one-cycle `start` pulse captures all operands and controls. `busy` stays high while the lanes are processed. A one-cycle `done` pulse marks the point where the result vector and the exception flags are final, and both then hold until the next accepted `start`.

Each lane can be enabled or disabled by a writemask. A disabled lane either keeps the old destination element or is cleared. Element 0 can be broadcast to all lanes when the operand comes from memory. The rounding mode comes from an embedded field only in one exact case, and from a global input otherwise. Destination bits above the active length are cleared, except in legacy mode, where they keep their old value.

Top module: `pk_fsqrt_unit`

## Requirements
- R1: `vlen` 00 selects 4 lanes, 01 selects 8, and 10 or 11 select 16. Lane j is `result[32j+31:32j]` and is computed from `src[32j+31:32j]`.
- R2: Rounding codes are 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. `emb_rm` is used only when the effective length is 16 lanes, `bcast`=1 and `src_is_mem`=0. Otherwise `glob_rm` is used.
- R3: With `bcast`=1 and `src_is_mem`=1, every computed lane takes the root of `src[31:0]`.
- R4: Lane j is computed when `mask_en`=0 or `wmask[j]`=1.
- R5: A lane that is not computed takes `dst_old` for that lane when `zero_mode`=0, or zero when `zero_mode`=1. It raises no flag.
- R6: Result bits above the active length are zero. When `legacy`=1 the unit works on 4 lanes, and `result[511:128]` equals `dst_old[511:128]`.
- R7: A finite positive input gives the correctly rounded root under the selected mode. `flag_inexact` is raised when the root is not exact.
- R8: The special inputs give these results:
  - A negative nonzero input, including minus infinity, gives 0xFFC00000 and raises `flag_inv`.
  - A zero of either sign returns itself.
  - Plus infinity returns plus infinity.
  - A NaN returns itself with bit 22 set. A signalling NaN (bit 22 clear) also raises `flag_inv`.
- R9: A denormal input (exponent 0, fraction nonzero) raises `flag_denorm`. A positive denormal still gets a correctly rounded root.
- R10: Flags are cleared on an accepted `start`. They collect the OR over all computed lanes and hold until the next accepted `start`.
- R11: After reset, `result`, `busy`, `done` and all flags are zero.
  - `busy` is high from the cycle after an accepted `start` until the cycle in which `done` pulses for one cycle.
  - A `start` while busy is ignored.
  - `result` holds while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture operands and begin (ignored while busy) |
| vlen | input | 2 | Vector length code |
| src | input | 512 | Source vector |
| dst_old | input | 512 | Previous destination contents |
| wmask | input | 16 | Per-lane writemask |
| mask_en | input | 1 | Apply `wmask` when 1 |
| zero_mode | input | 1 | 1 clears masked-off lanes, 0 merges |
| bcast | input | 1 | Broadcast / embedded-rounding enable bit |
| src_is_mem | input | 1 | Source operand comes from memory |
| legacy | input | 1 | Legacy 4-lane mode preserving upper bits |
| emb_rm | input | 2 | Embedded rounding mode |
| glob_rm | input | 2 | Global rounding mode |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 512 | Result vector |
| flag_inv | output | 1 | Sticky invalid flag |
| flag_inexact | output | 1 | Sticky precision flag |
| flag_denorm | output | 1 | Sticky denormal-operand flag |

## Verification
The assertions assume that `start` may arrive at any time. A pulse while busy must leave the operation, the result and the flags untouched. They also assume the inner engine is launched only while it is idle, which the lane sequencer guarantees. Operands are sampled only on an accepted `start`, so the bench changes inputs freely between operations. In one directed case it changes the inputs during a run together with a spurious `start`. Random operations draw lengths, masks, broadcast bits and rounding codes over their full legal ranges, including code 11 for `vlen`. The input values mix normals, zeros, denormals, infinities and both NaN kinds, so every special path is reached under masking.

// File: rtl/pk_fsqrt_pkg.sv
`timescale 1ns/1ps
// Shared constants and state types for the packed square root unit.
// Assumes single-precision (32-bit) lanes.
package pk_fsqrt_pkg;
    localparam int LANE_W   = 32;
    localparam int SIG_W    = 24;            // significand incl. hidden bit
    localparam int QW       = SIG_W + 1;     // root bits incl. guard
    localparam int XW       = 2 * QW;        // radicand width
    localparam int RMW      = QW + 1;        // partial remainder width
    localparam int CW       = $clog2(QW);    // iteration counter width
    localparam int LEG_LANES = 4;            // lanes of the shortest length
    localparam logic [LANE_W-1:0] DEF_NAN = 32'hFFC0_0000;
    localparam logic [LANE_W-1:0] QUIET_BIT = 32'h0040_0000;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rm_e;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_ITER  = 2'd1,
        CS_ROUND = 2'd2
    } core_st_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SCAN = 2'd1,
        SQ_WAIT = 2'd2
    } seq_st_e;
endpackage

// File: rtl/fsqrt_rnd.sv
`timescale 1ns/1ps
// Rounds a positive root given as QW bits (hidden, 23 fraction, guard) plus
// a sticky bit into a single-precision word. Assumes the root is positive and
// the biased exponent is far from both ends of its range.
module fsqrt_rnd
    import pk_fsqrt_pkg::*;
(
    input  logic [QW-1:0]     root,
    input  logic              sticky,
    input  logic [7:0]        bexp,
    input  logic [1:0]        rm,
    output logic [LANE_W-1:0] word,
    output logic              inexact
);
    logic [SIG_W-1:0] sig;
    logic             guard;
    logic             up;
    logic [SIG_W:0]   sum;

    // Decide the increment from the selected mode and form the packed word.
    always_comb begin
        sig     = root[QW-1:1];
        guard   = root[0];
        inexact = guard | sticky;
        case (rm)
            RM_NEAR: up = guard & (sticky | sig[0]);
            RM_UP:   up = guard | sticky;
            default: up = 1'b0;                 // down and zero truncate a positive root
        endcase
        sum = {1'b0, sig} + {{SIG_W{1'b0}}, up};
        if (sum[SIG_W])
            word = {1'b0, bexp + 8'd1, sum[SIG_W-1:1]};
        else
            word = {1'b0, bexp, sum[SIG_W-2:0]};
    end
endmodule

// File: rtl/fsqrt_core.sv
`timescale 1ns/1ps
// Single-lane square root engine. Special operands resolve in the launch
// cycle. Other operands are normalized, then run a restoring radix-2
// recurrence (one root bit per cycle, QW cycles) and are rounded in a final
// cycle. Assumes go is raised only while busy is low.
module fsqrt_core
    import pk_fsqrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [LANE_W-1:0] opnd,
    input  logic [1:0]        rm,
    output logic              busy,
    output logic              done,
    output logic [LANE_W-1:0] res,
    output logic              f_inv,
    output logic              f_inx,
    output logic              f_den
);
    core_st_e          st_q;
    logic [XW-1:0]     x_q;
    logic [RMW-1:0]    rem_q;
    logic [QW-1:0]     q_q;
    logic [CW-1:0]     cnt_q;
    logic [7:0]        bexp_q;
    logic [1:0]        rm_q;
    logic              den_q;

    logic              sgn;
    logic [7:0]        ex;
    logic [22:0]       fr;
    logic              is_nan, is_inf, is_zero, is_den;
    logic [4:0]        lz;
    logic              found;
    logic [SIG_W-1:0]  mant;
    logic signed [9:0] e_un;
    logic [QW-1:0]     m_rad;
    logic [7:0]        r_exp;
    logic              sp_hit, sp_inv;
    logic [LANE_W-1:0] sp_res;
    logic [RMW+1:0]    rem_t;
    logic [RMW+1:0]    trial;
    logic              ge;
    logic [LANE_W-1:0] rnd_word;
    logic              rnd_inx;

    assign {sgn, ex, fr} = opnd;
    assign is_nan  = (&ex) & (|fr);
    assign is_inf  = (&ex) & ~(|fr);
    assign is_zero = ~(|ex) & ~(|fr);
    assign is_den  = ~(|ex) & (|fr);
    assign busy    = (st_q != CS_IDLE);

    // Count leading zeros of the fraction for denormal normalization.
    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int b = 22; b >= 0; b--) begin
            if (!found) begin
                if (fr[b]) found = 1'b1;
                else       lz    = lz + 5'd1;
            end
        end
    end

    // Normalize, make the exponent even and derive the root exponent.
    always_comb begin
        mant  = is_den ? ({fr, 1'b0} << lz) : {1'b1, fr};
        e_un  = is_den ? (-10'sd127 - $signed({5'b0, lz}))
                       : ($signed({2'b00, ex}) - 10'sd127);
        m_rad = e_un[0] ? {mant, 1'b0} : {1'b0, mant};
        r_exp = 8'((e_un >>> 1) + 10'sd127);
    end

    // Resolve NaN, infinity, zero and negative operands without iterating.
    always_comb begin
        sp_hit = 1'b1;
        sp_inv = 1'b0;
        sp_res = opnd;
        if (is_nan) begin
            sp_res = opnd | QUIET_BIT;
            sp_inv = ~fr[22];
        end else if (is_zero || (is_inf && !sgn)) begin
            sp_res = opnd;
        end else if (sgn) begin
            sp_res = DEF_NAN;
            sp_inv = 1'b1;
        end else begin
            sp_hit = 1'b0;
        end
    end

    // One restoring step: bring down two radicand bits, trial-subtract.
    always_comb begin
        rem_t = {rem_q, x_q[XW-1:XW-2]};
        trial = {1'b0, q_q, 2'b01};
        ge    = (rem_t >= trial);
    end

    fsqrt_rnd u_rnd (
        .root    (q_q),
        .sticky  (|rem_q),
        .bexp    (bexp_q),
        .rm      (rm_q),
        .word    (rnd_word),
        .inexact (rnd_inx)
    );

    // Engine state machine: launch, iterate, round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CS_IDLE;
            x_q    <= '0;
            rem_q  <= '0;
            q_q    <= '0;
            cnt_q  <= '0;
            bexp_q <= '0;
            rm_q   <= '0;
            den_q  <= 1'b0;
            done   <= 1'b0;
            res    <= '0;
            f_inv  <= 1'b0;
            f_inx  <= 1'b0;
            f_den  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st_q)
                CS_IDLE: if (go) begin
                    rm_q  <= rm;
                    den_q <= is_den;
                    if (sp_hit) begin
                        res   <= sp_res;
                        f_inv <= sp_inv;
                        f_inx <= 1'b0;
                        f_den <= is_den;
                        done  <= 1'b1;
                    end else begin
                        x_q    <= {m_rad, {QW{1'b0}}};
                        rem_q  <= '0;
                        q_q    <= '0;
                        cnt_q  <= '0;
                        bexp_q <= r_exp;
                        st_q   <= CS_ITER;
                    end
                end
                CS_ITER: begin
                    q_q   <= {q_q[QW-2:0], ge};
                    rem_q <= ge ? RMW'(rem_t - trial) : RMW'(rem_t);
                    x_q   <= {x_q[XW-3:0], 2'b00};
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == CW'(QW - 1)) st_q <= CS_ROUND;
                end
                CS_ROUND: begin
                    res   <= rnd_word;
                    f_inx <= rnd_inx;
                    f_den <= den_q;
                    f_inv <= 1'b0;
                    done  <= 1'b1;
                    st_q  <= CS_IDLE;
                end
                default: st_q <= CS_IDLE;
            endcase
        end
    end

    // The sequencer never launches a busy engine (R11).
    assert_go_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (st_q == CS_IDLE));
    // An invalid outcome always carries a quiet NaN (R8).
    assert_inv_nan_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && f_inv) |-> (res[30:22] == 9'h1FF));
    // Engine completion is a single-cycle pulse (R11).
    assert_core_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/pk_fsqrt_unit.sv
`timescale 1ns/1ps
// Packed square root unit. Captures operands on start and presets the result
// with the merge/zero and upper-bit fill. It then walks the active lanes in
// order through one shared engine, writing each root into its lane and ORing
// the flags. Assumes NLANE is 16 so that the length codes map to 4/8/16 lanes.
module pk_fsqrt_unit
    import pk_fsqrt_pkg::*;
#(
    parameter int NLANE = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [1:0]              vlen,
    input  logic [NLANE*LANE_W-1:0] src,
    input  logic [NLANE*LANE_W-1:0] dst_old,
    input  logic [NLANE-1:0]        wmask,
    input  logic                    mask_en,
    input  logic                    zero_mode,
    input  logic                    bcast,
    input  logic                    src_is_mem,
    input  logic                    legacy,
    input  logic [1:0]              emb_rm,
    input  logic [1:0]              glob_rm,
    output logic                    busy,
    output logic                    done,
    output logic [NLANE*LANE_W-1:0] result,
    output logic                    flag_inv,
    output logic                    flag_inexact,
    output logic                    flag_denorm
);
    localparam int VW = NLANE * LANE_W;
    localparam int IW = $clog2(NLANE);
    localparam int KW = IW + 1;

    function automatic logic [KW-1:0] lanes_for(input logic [1:0] code);
        int n;
        n = LEG_LANES << code;
        if (n > NLANE) n = NLANE;
        return KW'(n);
    endfunction

    seq_st_e           st_q;
    logic [VW-1:0]     src_q;
    logic [VW-1:0]     res_q;
    logic [NLANE-1:0]  act_q;
    logic              bsrc_q;
    logic [1:0]        rm_q;
    logic [KW-1:0]     kl_q;
    logic [IW-1:0]     idx_q;
    logic              inv_q, inx_q, den_q;

    logic [1:0]        vl_eff;
    logic [KW-1:0]     kl_n;
    logic [NLANE-1:0]  act_n;
    logic [1:0]        rm_n;
    logic [VW-1:0]     init_vec;
    logic [LANE_W-1:0] op_lane;
    logic              lane_on;
    logic              last;
    logic              core_go;
    logic              core_busy, core_done;
    logic [LANE_W-1:0] core_res;
    logic              c_inv, c_inx, c_den;

    // Decode effective length, active lanes and rounding source at start.
    always_comb begin
        vl_eff = legacy ? 2'b00 : vlen;
        kl_n   = lanes_for(vl_eff);
        act_n  = mask_en ? wmask : {NLANE{1'b1}};
        rm_n   = (vl_eff[1] && bcast && !src_is_mem) ? emb_rm : glob_rm;
    end

    // Preset each lane: merged/zeroed when masked, filled above the length.
    for (genvar j = 0; j < NLANE; j++) begin : g_init
        assign init_vec[j*LANE_W +: LANE_W] =
            (KW'(j) < kl_n)
                ? ((act_n[j] || zero_mode) ? '0 : dst_old[j*LANE_W +: LANE_W])
                : (legacy ? dst_old[j*LANE_W +: LANE_W] : '0);
    end

    // Select the operand of the current lane, or element 0 when broadcasting.
    always_comb begin
        op_lane = src_q[LANE_W-1:0];
        if (!bsrc_q) begin
            for (int j = 0; j < NLANE; j++)
                if (IW'(j) == idx_q) op_lane = src_q[j*LANE_W +: LANE_W];
        end
        lane_on = act_q[idx_q];
        last    = ({1'b0, idx_q} == (kl_q - KW'(1)));
        core_go = (st_q == SQ_SCAN) && lane_on;
    end

    fsqrt_core u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (core_go),
        .opnd  (op_lane),
        .rm    (rm_q),
        .busy  (core_busy),
        .done  (core_done),
        .res   (core_res),
        .f_inv (c_inv),
        .f_inx (c_inx),
        .f_den (c_den)
    );

    // Lane sequencer: capture, skip or launch each lane, collect results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            src_q  <= '0;
            res_q  <= '0;
            act_q  <= '0;
            bsrc_q <= 1'b0;
            rm_q   <= '0;
            kl_q   <= '0;
            idx_q  <= '0;
            inv_q  <= 1'b0;
            inx_q  <= 1'b0;
            den_q  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st_q)
                SQ_IDLE: if (start) begin
                    src_q  <= src;
                    res_q  <= init_vec;
                    act_q  <= act_n;
                    bsrc_q <= bcast && src_is_mem;
                    rm_q   <= rm_n;
                    kl_q   <= kl_n;
                    idx_q  <= '0;
                    inv_q  <= 1'b0;
                    inx_q  <= 1'b0;
                    den_q  <= 1'b0;
                    st_q   <= SQ_SCAN;
                end
                SQ_SCAN: begin
                    if (lane_on) begin
                        st_q <= SQ_WAIT;
                    end else if (last) begin
                        done <= 1'b1;
                        st_q <= SQ_IDLE;
                    end else begin
                        idx_q <= idx_q + IW'(1);
                    end
                end
                SQ_WAIT: if (core_done) begin
                    for (int j = 0; j < NLANE; j++)
                        if (IW'(j) == idx_q) res_q[j*LANE_W +: LANE_W] <= core_res;
                    inv_q <= inv_q | c_inv;
                    inx_q <= inx_q | c_inx;
                    den_q <= den_q | c_den;
                    if (last) begin
                        done <= 1'b1;
                        st_q <= SQ_IDLE;
                    end else begin
                        idx_q <= idx_q + IW'(1);
                        st_q  <= SQ_SCAN;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy         = (st_q != SQ_IDLE);
    assign result       = res_q;
    assign flag_inv     = inv_q;
    assign flag_inexact = inx_q;
    assign flag_denorm  = den_q;

    // Completion is one cycle wide and coincides with leaving busy (R11).
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // Idle without start leaves result and flags untouched (R11, R10).
    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(result) && $stable(flag_inv)
                               && $stable(flag_inexact) && $stable(flag_denorm)));
    // Flags only accumulate during a run (R10).
    assert_inv_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && flag_inv) |=> flag_inv);
    // The lane pointer never leaves the active length (R1).
    assert_lane_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ({1'b0, idx_q} < kl_q));
    // The engine is only working while the unit is busy (R11).
    assert_core_inside_R11: assert property (@(posedge clk) disable iff (!rst_n)
        core_busy |-> busy);
endmodule

// File: tb/sim_pk_fsqrt_unit.sv
`timescale 1ns/1ps
module sim_pk_fsqrt_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   vlen = '0;
    logic [511:0] src = '0, dst_old = '0;
    logic [15:0]  wmask = '0;
    logic         mask_en = 0, zero_mode = 0, bcast = 0, src_is_mem = 0, legacy = 0;
    logic [1:0]   emb_rm = '0, glob_rm = '0;
    logic         busy, done, flag_inv, flag_inexact, flag_denorm;
    logic [511:0] result;

    int n_chk = 0, n_bad = 0;
    bit fin_done = 0;
    logic [511:0] exp_res;
    logic         e_inv, e_inx, e_den;
    int           cat [16];

    always #4 clk = ~clk;   // 125 MHz

    pk_fsqrt_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .src(src),
        .dst_old(dst_old), .wmask(wmask), .mask_en(mask_en), .zero_mode(zero_mode),
        .bcast(bcast), .src_is_mem(src_is_mem), .legacy(legacy), .emb_rm(emb_rm),
        .glob_rm(glob_rm), .busy(busy), .done(done), .result(result),
        .flag_inv(flag_inv), .flag_inexact(flag_inexact), .flag_denorm(flag_denorm));

    task automatic finish_run();
        if (!fin_done) begin
            fin_done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1600000;
        n_bad++;
        $display("FAIL R11 watchdog expired: actual hung expected finished");
        finish_run();
    end

    task automatic check(input string tag, input logic [511:0] act, input logic [511:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, act, expv);
        end
    endtask

    // Reference root: exact integer square root seeded by a real estimate.
    task automatic ref_lane(input logic [31:0] a, input logic [1:0] rm,
                            output logic [31:0] r, output logic inv,
                            output logic inx, output logic den);
        logic s; logic [7:0] e8; logic [22:0] f;
        longint m, xr, q; int p, ex; logic [23:0] sig; logic g, st, up;
        s = a[31]; e8 = a[30:23]; f = a[22:0];
        inv = 0; inx = 0; den = (e8 == 0 && f != 0); r = a;
        if (e8 == 8'hFF) begin
            if (f != 0) begin r = a | 32'h0040_0000; inv = !f[22]; end
            else if (s) begin r = 32'hFFC0_0000; inv = 1; end
        end else if (e8 == 0 && f == 0) begin
            r = a;
        end else if (s) begin
            r = 32'hFFC0_0000; inv = 1;
        end else begin
            if (e8 == 0) begin m = longint'(f); p = -149; end
            else begin m = longint'({1'b1, f}); p = int'(e8) - 150; end
            while (m < 64'd8388608) begin m = m * 2; p = p - 1; end
            if (p % 2 == 0) begin m = m * 2; p = p - 1; end
            xr = m * 64'd33554432;
            q = longint'($sqrt(real'(xr)));
            while (q * q > xr) q--;
            while ((q + 1) * (q + 1) <= xr) q++;
            sig = q[24:1]; g = q[0]; st = (q * q != xr);
            up = (rm == 2'b00) ? (g && (st || sig[0])) : (rm == 2'b10) ? (g || st) : 1'b0;
            ex = 24 + (p - 25) / 2 + 127;
            if (sig == 24'hFFFFFF && up) begin sig = 24'h800000; ex++; end
            else sig = sig + 24'(up);
            r = {1'b0, 8'(ex), sig[22:0]};
            inx = g || st;
        end
    endtask

    // Expected vector and flags from the currently driven controls.
    task automatic model();
        int kl; logic [1:0] rm; logic [31:0] a, r; logic i, x, d;
        kl = legacy ? 4 : (vlen == 0 ? 4 : (vlen == 1 ? 8 : 16));
        rm = (!legacy && vlen[1] && bcast && !src_is_mem) ? emb_rm : glob_rm;
        e_inv = 0; e_inx = 0; e_den = 0;
        for (int j = 0; j < 16; j++) begin
            if (j < kl) begin
                if (!mask_en || wmask[j]) begin
                    a = (bcast && src_is_mem) ? src[31:0] : src[j*32 +: 32];
                    ref_lane(a, rm, r, i, x, d);
                    exp_res[j*32 +: 32] = r;
                    e_inv |= i; e_inx |= x; e_den |= d;
                    cat[j] = 0;
                end else begin
                    exp_res[j*32 +: 32] = zero_mode ? 32'h0 : dst_old[j*32 +: 32];
                    cat[j] = 1;
                end
            end else begin
                exp_res[j*32 +: 32] = legacy ? dst_old[j*32 +: 32] : 32'h0;
                cat[j] = 2;
            end
        end
    endtask

    // One operation: predict, start, wait for done, compare lanes and flags.
    task automatic run_op(input string tag, input bit inject);
        int w;
        model();
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        if (inject) begin
            repeat (3) @(negedge clk);
            start = 1; src = ~src; wmask = ~wmask; zero_mode = ~zero_mode;
            @(negedge clk) start = 0;
        end
        w = 0;
        while (!done && w < 6000) begin @(negedge clk); w++; end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R11 no done: actual 0 expected 1");
            return;
        end
        for (int j = 0; j < 16; j++)
            check(cat[j] == 0 ? tag : (cat[j] == 1 ? "R5" : "R6"),
                  512'(result[j*32 +: 32]), 512'(exp_res[j*32 +: 32]));
        check({tag, " R10 flags"}, 512'({flag_inv, flag_inexact, flag_denorm}),
              512'({e_inv, e_inx, e_den}));
        check("R11 busy at done", 512'(busy), 512'(0));
        @(negedge clk);
        check("R11 done width", 512'(done), 512'(0));
    endtask

    function automatic logic [31:0] rnd_f();
        case ($urandom % 12)
            0: return {1'($urandom), 31'h0};
            1: return {1'($urandom), 8'h00, 23'($urandom) | 23'h1};
            2: return {1'($urandom), 8'hFF, 23'h0};
            3: return {1'($urandom), 8'hFF, 23'($urandom) | 23'h1};
            4: return {1'b1, 8'($urandom_range(1, 254)), 23'($urandom)};
            default: return {1'b0, 8'($urandom_range(1, 254)), 23'($urandom)};
        endcase
    endfunction

    task automatic clear_ctl();
        mask_en = 0; zero_mode = 0; bcast = 0; src_is_mem = 0; legacy = 0;
        emb_rm = 0; glob_rm = 0; wmask = '0;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        for (int j = 0; j < 16; j++) dst_old[j*32 +: 32] = $urandom;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        check("R11 reset result", result, '0);
        check("R11 reset ctl", 512'({busy, done, flag_inv, flag_inexact, flag_denorm}), 512'(0));

        // R1 / R7: exact and inexact roots on 4 lanes, upper lanes cleared
        clear_ctl(); vlen = 2'b00;
        src[31:0] = 32'h4080_0000; src[63:32] = 32'h4110_0000;
        src[95:64] = 32'h4000_0000; src[127:96] = 32'h3E80_0000;
        run_op("R1 R7", 0);

        // R8 / R9: special values across 16 lanes
        vlen = 2'b10;
        src[0*32 +: 32] = 32'hBF80_0000; src[1*32 +: 32] = 32'h8000_0000;
        src[2*32 +: 32] = 32'h7F80_0000; src[3*32 +: 32] = 32'h7FC1_2345;
        src[4*32 +: 32] = 32'h7F80_0001; src[5*32 +: 32] = 32'h0000_0001;
        src[6*32 +: 32] = 32'h0000_0000; src[7*32 +: 32] = 32'hFF80_0000;
        src[8*32 +: 32] = 32'h007F_FFFF; src[9*32 +: 32] = 32'h8000_0005;
        src[10*32 +: 32] = 32'h7F7F_FFFF; src[11*32 +: 32] = 32'h0080_0000;
        for (int j = 12; j < 16; j++) src[j*32 +: 32] = 32'h3F80_0000;
        run_op("R8 R9", 0);

        // R3: broadcast of element 0 from memory on 8 lanes
        for (int j = 0; j < 16; j++) src[j*32 +: 32] = 32'h4100_0000 + j;
        src[31:0] = 32'h4000_0000; vlen = 2'b01; bcast = 1; src_is_mem = 1;
        run_op("R3", 0);

        // R2: embedded mode used (16 lanes, broadcast bit, register source)
        for (int j = 0; j < 16; j++) src[j*32 +: 32] = 32'h4000_0000;
        vlen = 2'b10; bcast = 1; src_is_mem = 0; emb_rm = 2'b10; glob_rm = 2'b00;
        run_op("R2", 0);
        check("R2 round up lane0", 512'(result[31:0]), 512'(32'h3FB5_04F4));
        // R2: same controls at 8 lanes fall back to the global mode
        vlen = 2'b01;
        run_op("R2", 0);
        check("R2 global lane0", 512'(result[31:0]), 512'(32'h3FB5_04F3));

        // R4 / R5: merging then zeroing with a signalling NaN in a masked lane
        clear_ctl(); vlen = 2'b11; mask_en = 1; wmask = 16'hA5C3;
        for (int j = 0; j < 16; j++) src[j*32 +: 32] = 32'h4200_0000 + 32'(j * 77);
        src[2*32 +: 32] = 32'h7F80_0001;
        run_op("R4", 0);
        zero_mode = 1;
        run_op("R4", 0);

        // R6: legacy keeps upper bits; 8-lane mode clears them
        clear_ctl(); legacy = 1; vlen = 2'b10;
        run_op("R6", 0);
        legacy = 0; vlen = 2'b01;
        run_op("R6", 0);

        // R11: start while busy is ignored
        clear_ctl(); vlen = 2'b01; glob_rm = 2'b01;
        run_op("R11", 1);

        // R10: flags set by one run are cleared by the next
        clear_ctl(); vlen = 2'b00; src[31:0] = 32'h7F80_0001;
        run_op("R10", 0);
        src[31:0] = 32'h4080_0000;
        run_op("R10", 0);

        // R7: constrained random operations
        for (int t = 0; t < 40; t++) begin
            for (int j = 0; j < 16; j++) begin
                src[j*32 +: 32] = rnd_f();
                dst_old[j*32 +: 32] = $urandom;
            end
            vlen = 2'($urandom); wmask = 16'($urandom);
            mask_en = 1'($urandom); zero_mode = 1'($urandom);
            bcast = ($urandom % 4) == 0; src_is_mem = 1'($urandom);
            legacy = ($urandom % 6) == 0;
            emb_rm = 2'($urandom); glob_rm = 2'($urandom);
            run_op("R7", 0);
        end
        finish_run();
    end
endmodule